// File: doc/BRIEF.md
# Gated Pulse On-Time Meter

The block measures how long a gate pulse stays high, counted in cycles of the clock that also runs the pulse generator, so the reading is exact to one cycle. A one-cycle arm strobe starts a measurement. The meter then waits for the gate to rise. It counts every clock edge at which the gate is high and stops when the gate falls.

If the gate is still high after a parameterised number of cycles, the meter abandons the capture and raises a timeout flag, so a stuck gate never leaves it waiting. The default limit is 176 cycles, which is 11 us at 16 MHz and just past a 10 us nominal period. Surrounding logic compares the captured on-time against the commanded duty. A reading well below the commanded value points to hardware current limiting or a short.

Top module: `pulse_ontime_meter`

## Requirements
- R1: While reset is high and in the cycle after it, `on_count` is 0 and both `done_ok` and `done_timeout` are 0.
- R2: After an arm, a rising edge of `gate` starts a capture. If `gate` is sampled high on N consecutive clock edges, with 1 ≤ N ≤ LIMIT, then `done_ok` is 1 and `on_count` equals N from the clock edge that first samples `gate` low.
- R3: If `gate` is sampled high on more than LIMIT consecutive edges, `done_timeout` becomes 1 at edge LIMIT+1 and `on_count` holds LIMIT. `on_count` never exceeds LIMIT.
- R4: `done_ok` and `done_timeout` are never 1 together.
- R5: After a result, `on_count` and both flags hold until the next arm. At the edge that samples `arm` high, the flags clear and `on_count` returns to 0.
- R6: A `gate` that is already high when the arm is sampled is not measured. Only a later low-to-high transition starts the capture.
- R7: Pulses that arrive after a result and before the next arm do not change `on_count` or the flags.
- R8: An arm that arrives during a capture abandons that capture and waits for a fresh rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the pulse generator |
| rst | input | 1 | Synchronous active-high reset |
| arm | input | 1 | One-cycle strobe that starts a new capture |
| gate | input | 1 | Monitored gate signal |
| on_count | output | $clog2(LIMIT+1) | Captured high time in cycles |
| done_ok | output | 1 | Capture ended on a falling edge |
| done_timeout | output | 1 | Capture abandoned at the limit |

## Verification
Each result is registered once, so it is due at the first clock edge that samples the triggering input. The flags and the cleared count appear one edge after `arm` is sampled. `done_ok` appears one edge after `gate` is first sampled low. `done_timeout` appears at high-sample LIMIT+1. The bench changes inputs on falling edges and reads outputs on the next falling edge, half a period after the edge that updates them. In the timeout scenario it also reads one cycle earlier, to confirm the flag has not risen too soon.

// File: rtl/pom_pkg.sv
package pom_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_MEAS = 2'd2
    } pom_state_e;

    typedef struct packed {
        logic clr;
        logic start;
        logic inc;
    } cnt_ctl_t;

    function automatic int cnt_width(input int limit);
        return $clog2(limit + 1);
    endfunction
endpackage

// File: rtl/pom_edge.sv
module pom_edge (
    input  logic clk,
    input  logic rst,
    input  logic gate,
    output logic rise,
    output logic fall
);
    logic gate_q;

    always_ff @(posedge clk) begin
        if (rst) gate_q <= 1'b0;
        else     gate_q <= gate;
    end

    assign rise = gate & ~gate_q;
    assign fall = ~gate & gate_q;
endmodule

// File: rtl/pom_counter.sv
module pom_counter
    import pom_pkg::*;
#(
    parameter int LIMIT = 176,
    localparam int CW = cnt_width(LIMIT)
) (
    input  logic          clk,
    input  logic          rst,
    input  cnt_ctl_t      ctl,
    output logic [CW-1:0] cnt,
    output logic          at_limit
);
    localparam logic [CW-1:0] LIM_C = CW'(LIMIT);

    always_ff @(posedge clk) begin
        if (rst)            cnt <= '0;
        else if (ctl.clr)   cnt <= '0;
        else if (ctl.start) cnt <= CW'(1);
        else if (ctl.inc)   cnt <= cnt + CW'(1);
    end

    assign at_limit = (cnt == LIM_C);

    // R3: count never runs past the limit
    p_count_cap_r3: assert property (@(posedge clk) disable iff (rst)
        cnt <= LIM_C);
endmodule

// File: rtl/pom_ctrl.sv
module pom_ctrl
    import pom_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     arm,
    input  logic     gate,
    input  logic     rise,
    input  logic     at_limit,
    output cnt_ctl_t ctl,
    output logic     done_ok,
    output logic     done_timeout
);
    pom_state_e state;

    always_comb begin
        ctl.clr   = arm;
        ctl.start = !arm && (state == ST_WAIT) && rise;
        ctl.inc   = !arm && (state == ST_MEAS) && gate && !at_limit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= ST_IDLE;
            done_ok      <= 1'b0;
            done_timeout <= 1'b0;
        end else if (arm) begin
            state        <= ST_WAIT;
            done_ok      <= 1'b0;
            done_timeout <= 1'b0;
        end else begin
            case (state)
                ST_WAIT: if (rise) state <= ST_MEAS;
                ST_MEAS: begin
                    if (!gate) begin
                        state   <= ST_IDLE;
                        done_ok <= 1'b1;
                    end else if (at_limit) begin
                        state        <= ST_IDLE;
                        done_timeout <= 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    p_flags_excl_r4: assert property (@(posedge clk) disable iff (rst)
        !(done_ok && done_timeout));
    p_arm_clears_r5: assert property (@(posedge clk) disable iff (rst)
        arm |=> (!done_ok && !done_timeout));
    p_ok_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (done_ok && !arm) |=> done_ok);
    p_to_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (done_timeout && !arm) |=> done_timeout);
    p_ok_on_low_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(done_ok) |-> !$past(gate));
    p_to_on_high_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(done_timeout) |-> $past(gate));
endmodule

// File: rtl/pulse_ontime_meter.sv
module pulse_ontime_meter
    import pom_pkg::*;
#(
    parameter int LIMIT = 176,
    localparam int CW = cnt_width(LIMIT)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          arm,
    input  logic          gate,
    output logic [CW-1:0] on_count,
    output logic          done_ok,
    output logic          done_timeout
);
    logic     rise;
    logic     fall;
    logic     at_limit;
    cnt_ctl_t ctl;

    pom_edge u_edge (
        .clk  (clk),
        .rst  (rst),
        .gate (gate),
        .rise (rise),
        .fall (fall)
    );

    pom_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .arm          (arm),
        .gate         (gate),
        .rise         (rise),
        .at_limit     (at_limit),
        .ctl          (ctl),
        .done_ok      (done_ok),
        .done_timeout (done_timeout)
    );

    pom_counter #(.LIMIT(LIMIT)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .ctl      (ctl),
        .cnt      (on_count),
        .at_limit (at_limit)
    );

    // R2: a completed capture coincides with a falling edge having been seen
    p_fall_seen_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(done_ok) |-> $past(fall));
endmodule

// File: tb/test_pulse_ontime_meter.sv
module test_pulse_ontime_meter;
    localparam int LIMIT = 12;
    localparam int CW = $clog2(LIMIT + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic arm = 1'b0;
    logic gate = 1'b0;
    logic [CW-1:0] on_count;
    logic done_ok;
    logic done_timeout;
    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    pulse_ontime_meter #(.LIMIT(LIMIT)) i_pulse_ontime_meter (
        .clk(clk), .rst(rst), .arm(arm), .gate(gate),
        .on_count(on_count), .done_ok(done_ok), .done_timeout(done_timeout)
    );

    task automatic check(input string req, input int cnt_exp,
                         input bit ok_exp, input bit to_exp);
        n_chk++;
        if (on_count !== CW'(cnt_exp) || done_ok !== ok_exp || done_timeout !== to_exp) begin
            n_bad++;
            $display("FAIL %s: count/ok/timeout = %0d/%0b/%0b, expected %0d/%0b/%0b",
                     req, on_count, done_ok, done_timeout, cnt_exp, ok_exp, to_exp);
        end
    endtask

    task automatic do_arm();
        arm = 1'b1;
        @(negedge clk);
        arm = 1'b0;
    endtask

    task automatic pulse(input int n);
        gate = 1'b1;
        repeat (n) @(negedge clk);
        gate = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (2) @(negedge clk);
        check("R1 in reset", 0, 0, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset", 0, 0, 0);
    endtask

    task automatic t_measure(input int n);
        do_arm();
        check("R5 arm clears", 0, 0, 0);
        pulse(n);
        check("R2 pulse width", n, 1, 0);
        check("R4 exclusive flags", n, 1, 0);
    endtask

    task automatic t_ignore_after_result();
        do_arm();
        pulse(3);
        check("R2 before ignore", 3, 1, 0);
        repeat (2) @(negedge clk);
        pulse(7);
        check("R7 pulse without arm", 3, 1, 0);
        check("R5 result held", 3, 1, 0);
    endtask

    task automatic t_timeout();
        do_arm();
        gate = 1'b1;
        repeat (LIMIT) @(negedge clk);
        check("R3 no early timeout", LIMIT, 0, 0);
        @(negedge clk);
        check("R3 timeout at limit+1", LIMIT, 0, 1);
        gate = 1'b0;
        repeat (2) @(negedge clk);
        check("R5 timeout held", LIMIT, 0, 1);
        do_arm();
        check("R5 arm clears timeout", 0, 0, 0);
    endtask

    task automatic t_high_at_arm();
        gate = 1'b1;
        @(negedge clk);
        do_arm();
        repeat (3) @(negedge clk);
        gate = 1'b0;
        repeat (2) @(negedge clk);
        check("R6 high at arm not measured", 0, 0, 0);
        pulse(5);
        check("R6 next rising edge measured", 5, 1, 0);
    endtask

    task automatic t_rearm_mid();
        do_arm();
        gate = 1'b1;
        repeat (3) @(negedge clk);
        do_arm();
        check("R8 rearm clears", 0, 0, 0);
        @(negedge clk);
        gate = 1'b0;
        repeat (2) @(negedge clk);
        check("R8 old capture dropped", 0, 0, 0);
        pulse(4);
        check("R8 fresh capture", 4, 1, 0);
    endtask

    initial begin
        t_reset();
        t_measure(1);
        t_measure(6);
        t_measure(LIMIT);
        t_ignore_after_result();
        t_timeout();
        t_high_at_arm();
        t_rearm_mid();
        finished = 1'b1;
    end

    initial begin
        fork
            wait (finished);
            begin
                repeat (5000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: run did not finish, expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule